// File: doc/BRIEF.md
# Dual-Word Store Execution Unit

This block carries out a "store two registers" operation for a processor pipeline. It accepts an instruction word in either of two encodings: a 32-bit conditional form, or a compact form made of two halfwords. Alongside the word it takes a condition-passed flag, an endianness flag, the base-register value and the two data-register values. It decodes the fields and rejects encodings it does not accept. It forms an offset address and an access address, and writes both data words to memory over a valid/ready request port.

An access address that is a multiple of eight bytes produces a single 8-byte beat, and the endianness flag picks the word order inside it. Any other address produces two 4-byte beats at consecutive word addresses. After the last beat is accepted, the block pulses `done` for one cycle. In that same cycle it may present a base-register writeback, or it may flag the operation as undefined. The register indices that the instruction names are decoded combinationally, so the register file can read the operands before the start pulse.

Top module: `dstore_unit`

## Requirements
- R1: With `isCompact`=0 the word is accepted when bits 31:28 differ from 1111, bits 27:25 are 000, bit 22 is 1, bit 20 is 0 and bits 7:4 are 1111. In that form P is bit 24, U is bit 23, W is bit 21, the base index is bits 19:16 and the first data index is bits 15:12. The offset is {bits 11:8, bits 3:0} zero-extended. The second data index is the first plus one. `srcIdxA`/`srcIdxB` show both data indices.
- R2: With `isCompact`=1, bits 31:16 are the first halfword and bits 15:0 the second. The first halfword must be 1110100 in bits 15:9, 1 in bit 6 and 0 in bit 4. In it, P is bit 8, U is bit 7, W is bit 5 and the base index is bits 3:0. The second halfword gives the first data index in bits 15:12 and the second in bits 11:8. Its bits 7:0, shifted left by two, form the offset.
- R3: The offset address is base+offset when U=1 and base−offset when U=0. The access address is the offset address when P=1 and the base when P=0.
- R4: An access address that is a multiple of 8 gives exactly one beat with `memWide`=1. In little-endian mode (`bigEndian`=0) the first data value sits in `memData[31:0]` and the second in bits 63:32. In big-endian mode the two words are swapped.
- R5: Any other access address gives two beats with `memWide`=0. The first carries the first data value to the access address. The second carries the second data value to the access address plus 4. The data sits in `memData[31:0]`, and the upper bits are zero.
- R6: Writeback is enabled when P=0 or W=1 in the 32-bit form, and only when W=1 in the compact form. When enabled, `wbValid` is high in the `done` cycle, with `wbReg` equal to the base index and `wbValue` equal to the offset address. Outside that case `wbValid` stays low.
- R7: These accepted encodings are undefined:
  - in the 32-bit form, an odd first data index;
  - in the 32-bit form, P=0 together with W=1;
  - a data index of 15;
  - writeback with a base index equal to either data index;
  - writeback with base index 15 in the 32-bit form;
  - base index 15 at all in the compact form.
  
  An undefined encoding makes no memory request and no writeback. It pulses `done` and `undef` together one cycle after the start.
- R8: An encoding that does not match its form is treated as undefined, with the same behaviour as in R7. In the compact form this includes P=0 with W=0.
- R9: With `condPass`=0 there is no memory request, no writeback and no `undef`, and `done` pulses one cycle after the start.
- R10: While `memValid` is high and `memReady` is low, `memValid`, `memAddr`, `memData` and `memWide` hold their values.
- R11: `done` is a one-cycle pulse in the cycle after the final accepted beat. The first beat is presented in the cycle after the start. The cycle count depends only on alignment and `memReady`, never on data values.
- R12: `busy` is high from the cycle after an accepted start through the `done` cycle. A `cmdStart` or an input change while `busy` is high has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse; taken when `busy` is low |
| isCompact | input | 1 | 1 selects the two-halfword encoding |
| insnWord | input | 32 | Instruction word |
| condPass | input | 1 | Condition check result |
| bigEndian | input | 1 | 1 selects big-endian word order |
| baseVal | input | 32 | Base register value |
| dataA | input | 32 | First data register value |
| dataB | input | 32 | Second data register value |
| srcIdxA | output | 4 | Decoded first data register index |
| srcIdxB | output | 4 | Decoded second data register index |
| busy | output | 1 | Operation in progress |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory request accepted |
| memAddr | output | 32 | Request byte address |
| memData | output | 64 | Request data |
| memWide | output | 1 | 1 = 8-byte beat, 0 = 4-byte beat |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Undefined encoding, valid with `done` |
| wbValid | output | 1 | Base writeback request, valid with `done` |
| wbReg | output | 4 | Base register index to write |
| wbValue | output | 32 | Value for the base register |

## Verification
The hardest case to reach is a two-beat store that stalls on the memory port while a fresh start pulse and new operand values appear on the inputs. A wrong design would either re-latch those values or lose the second beat's address step. The bench builds that case by choosing base and offset values that give a word-aligned but not doubleword-aligned address. It then holds `memReady` low on chosen cycles and, in the first busy cycle, drives `cmdStart` with inverted base and data values. A behavioural model predicts every output cycle by cycle, so any leak of the new values shows up at the ports.

// File: rtl/dstore_pkg.sv
package dstore_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned IMM_W  = 10;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture operands and addresses
    logic execute;  // captured operation will really store
    logic second;   // present the second word beat
  } ctlStrobes_t;

endpackage

// File: rtl/dstore_decode.sv
module dstore_decode
  import dstore_pkg::*;
(
  input  logic              isCompact,
  input  logic [INSN_W-1:0] insnWord,
  output logic              match,
  output logic              bad,
  output logic              isIndex,
  output logic              isAdd,
  output logic              wback,
  output logic [IDX_W-1:0]  rn,
  output logic [IDX_W-1:0]  rt,
  output logic [IDX_W-1:0]  rt2,
  output logic [IMM_W-1:0]  imm
);

  localparam logic [IDX_W-1:0] PC_IDX = '1;

  logic [15:0] hwHi, hwLo;
  logic        wideMatch, cmpMatch;
  logic        wideBad, cmpBad;

  assign hwHi = insnWord[31:16];
  assign hwLo = insnWord[15:0];

  assign wideMatch = (insnWord[31:28] != 4'hF) && (insnWord[27:25] == 3'b000) &&
                     insnWord[22] && !insnWord[20] && (insnWord[7:4] == 4'hF);
  assign cmpMatch  = (hwHi[15:9] == 7'b1110100) && hwHi[6] && !hwHi[4] &&
                     (hwHi[8] || hwHi[5]);

  always_comb begin
    if (isCompact) begin
      isIndex = hwHi[8];
      isAdd   = hwHi[7];
      wback   = hwHi[5];
      rn      = hwHi[3:0];
      rt      = hwLo[15:12];
      rt2     = hwLo[11:8];
      imm     = {hwLo[7:0], 2'b00};
      match   = cmpMatch;
    end else begin
      isIndex = insnWord[24];
      isAdd   = insnWord[23];
      wback   = !insnWord[24] || insnWord[21];
      rn      = insnWord[19:16];
      rt      = insnWord[15:12];
      rt2     = insnWord[15:12] + IDX_W'(1);
      imm     = {2'b00, insnWord[11:8], insnWord[3:0]};
      match   = wideMatch;
    end
  end

  assign wideBad = rt[0] || (!isIndex && insnWord[21]) || (rt2 == PC_IDX) ||
                   (wback && (rn == rt || rn == rt2 || rn == PC_IDX));
  assign cmpBad  = (rn == PC_IDX) || (rt == PC_IDX) || (rt2 == PC_IDX) ||
                   (wback && (rn == rt || rn == rt2));
  assign bad     = isCompact ? cmpBad : wideBad;

endmodule

// File: rtl/dstore_ctrl.sv
module dstore_ctrl
  import dstore_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        condPass,
  input  logic        match,
  input  logic        bad,
  input  logic        aligned,
  input  logic        memReady,
  output ctlStrobes_t stb,
  output logic        busy,
  output logic        memValid,
  output logic        done,
  output logic        undef
);

  typedef enum logic [1:0] {S_IDLE, S_BEAT0, S_BEAT1, S_FIN} state_t;

  state_t state, stateNext;
  logic   undefReg;
  logic   goNow;

  assign goNow = condPass && match && !bad;

  always_comb begin
    stateNext   = state;
    stb.load    = 1'b0;
    stb.execute = 1'b0;
    stb.second  = (state == S_BEAT1);
    case (state)
      S_IDLE: if (cmdStart) begin
        stb.load    = 1'b1;
        stb.execute = goNow;
        stateNext   = goNow ? S_BEAT0 : S_FIN;
      end
      S_BEAT0: if (memReady) stateNext = aligned ? S_FIN : S_BEAT1;
      S_BEAT1: if (memReady) stateNext = S_FIN;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      undefReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.load) undefReg <= condPass && !(match && !bad);
    end
  end

  assign busy     = (state != S_IDLE);
  assign memValid = (state == S_BEAT0) || (state == S_BEAT1);
  assign done     = (state == S_FIN);
  assign undef    = done && undefReg;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart && !busy |=> busy); // R12
  AST_UNDEF_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    undef |-> !memValid && !$past(memValid)); // R7

endmodule

// File: rtl/dstore_datapath.sv
module dstore_datapath
  import dstore_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         stb,
  input  logic                isIndex,
  input  logic                isAdd,
  input  logic                wback,
  input  logic [IDX_W-1:0]    rn,
  input  logic [IMM_W-1:0]    imm,
  input  logic                bigEndian,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [WORD_W-1:0]   dataA,
  input  logic [WORD_W-1:0]   dataB,
  output logic                aligned,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*WORD_W-1:0] memData,
  output logic                memWide,
  output logic                wbEn,
  output logic [IDX_W-1:0]    wbReg,
  output logic [ADDR_W-1:0]   wbValue
);

  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned ALIGN_BITS = $clog2(2 * WORD_BYTES);

  logic [ADDR_W-1:0] immExt, offNext, accNext;
  logic [ADDR_W-1:0] offAddr, accAddr;
  logic [WORD_W-1:0] wordA, wordB;
  logic              beLatched;

  assign immExt  = {{(ADDR_W-IMM_W){1'b0}}, imm};
  assign offNext = isAdd ? baseVal + immExt : baseVal - immExt;
  assign accNext = isIndex ? offNext : baseVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offAddr   <= '0;
      accAddr   <= '0;
      wordA     <= '0;
      wordB     <= '0;
      beLatched <= 1'b0;
      wbEn      <= 1'b0;
      wbReg     <= '0;
    end else if (stb.load) begin
      offAddr   <= offNext;
      accAddr   <= accNext;
      wordA     <= dataA;
      wordB     <= dataB;
      beLatched <= bigEndian;
      wbEn      <= stb.execute && wback;
      wbReg     <= rn;
    end
  end

  assign aligned = (accAddr[ALIGN_BITS-1:0] == '0);
  assign memWide = aligned && !stb.second;
  assign memAddr = stb.second ? accAddr + ADDR_W'(WORD_BYTES) : accAddr;
  assign wbValue = offAddr;

  always_comb begin
    if (memWide) memData = beLatched ? {wordA, wordB} : {wordB, wordA};
    else         memData = {{WORD_W{1'b0}}, stb.second ? wordB : wordA};
  end

endmodule

// File: rtl/dstore_unit.sv
module dstore_unit
  import dstore_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdStart,
  input  logic                isCompact,
  input  logic [INSN_W-1:0]   insnWord,
  input  logic                condPass,
  input  logic                bigEndian,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [WORD_W-1:0]   dataA,
  input  logic [WORD_W-1:0]   dataB,
  output logic [IDX_W-1:0]    srcIdxA,
  output logic [IDX_W-1:0]    srcIdxB,
  output logic                busy,
  output logic                memValid,
  input  logic                memReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*WORD_W-1:0] memData,
  output logic                memWide,
  output logic                done,
  output logic                undef,
  output logic                wbValid,
  output logic [IDX_W-1:0]    wbReg,
  output logic [ADDR_W-1:0]   wbValue
);

  ctlStrobes_t      stb;
  logic             match, bad, isIndex, isAdd, wback, aligned, wbEn;
  logic [IDX_W-1:0] rn;
  logic [IMM_W-1:0] imm;

  dstore_decode u_decode (
    .isCompact(isCompact), .insnWord(insnWord), .match(match), .bad(bad),
    .isIndex(isIndex), .isAdd(isAdd), .wback(wback), .rn(rn),
    .rt(srcIdxA), .rt2(srcIdxB), .imm(imm)
  );

  dstore_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .condPass(condPass),
    .match(match), .bad(bad), .aligned(aligned), .memReady(memReady),
    .stb(stb), .busy(busy), .memValid(memValid), .done(done), .undef(undef)
  );

  dstore_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .isIndex(isIndex), .isAdd(isAdd),
    .wback(wback), .rn(rn), .imm(imm), .bigEndian(bigEndian),
    .baseVal(baseVal), .dataA(dataA), .dataB(dataB), .aligned(aligned),
    .memAddr(memAddr), .memData(memData), .memWide(memWide),
    .wbEn(wbEn), .wbReg(wbReg), .wbValue(wbValue)
  );

  assign wbValid = done && wbEn;

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData) && $stable(memWide)); // R10
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && !memWide |=> !memValid || (memAddr == $past(memAddr) + ADDR_W'(WORD_W/8))); // R5
  AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done && !undef); // R6
  AST_WIDE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady && memWide |=> !memValid && done); // R4

endmodule

// File: tb/dstore_unit_bench.sv
`timescale 1ns/1ps
module dstore_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0, isCompact = 1'b0, condPass = 1'b0, bigEndian = 1'b0;
  logic [31:0] insnWord = '0, baseVal = '0, dataA = '0, dataB = '0;
  logic [3:0]  srcIdxA, srcIdxB, wbReg;
  logic        busy, memValid, memReady = 1'b1, memWide, done, undef, wbValid;
  logic [31:0] memAddr, wbValue;
  logic [63:0] memData;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dstore_unit u_dstore_unit (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .isCompact(isCompact),
    .insnWord(insnWord), .condPass(condPass), .bigEndian(bigEndian),
    .baseVal(baseVal), .dataA(dataA), .dataB(dataB), .srcIdxA(srcIdxA),
    .srcIdxB(srcIdxB), .busy(busy), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memData(memData), .memWide(memWide), .done(done),
    .undef(undef), .wbValid(wbValid), .wbReg(wbReg), .wbValue(wbValue)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] encW(input logic [3:0] cnd, input bit p, input bit u, input bit w,
                                       input logic [3:0] rn, input logic [3:0] rt, input logic [7:0] im);
    return {cnd, 3'b000, p, u, 1'b1, w, 1'b0, rn, rt, im[7:4], 4'hF, im[3:0]};
  endfunction

  function automatic logic [31:0] encC(input bit p, input bit u, input bit w, input logic [3:0] rn,
                                       input logic [3:0] rt, input logic [3:0] rt2, input logic [7:0] im);
    return {7'b1110100, p, u, 1'b1, w, 1'b0, rn, rt, rt2, im};
  endfunction

  // behavioural decode, written from the requirement text
  task automatic model(input bit cmp, input logic [31:0] w, output bit ok, output bit isBad,
                       output bit wb, output bit p, output bit u, output int rn, output int rt,
                       output int rt2, output int imm);
    if (cmp) begin
      p = w[24]; u = w[23]; wb = w[21]; rn = w[19:16];
      rt = w[15:12]; rt2 = w[11:8]; imm = w[7:0] * 4;
      ok = (w[31:25] == 7'b1110100) && w[22] && !w[20] && (p || wb);
      isBad = (rn == 15) || (rt == 15) || (rt2 == 15) || (wb && (rn == rt || rn == rt2));
    end else begin
      p = w[24]; u = w[23]; wb = !p || w[21]; rn = w[19:16];
      rt = w[15:12]; rt2 = (rt + 1) % 16; imm = w[11:8] * 16 + w[3:0];
      ok = (w[31:28] != 4'hF) && (w[27:25] == 0) && w[22] && !w[20] && (w[7:4] == 4'hF);
      isBad = (rt % 2 == 1) || (!p && w[21]) || (rt2 == 15) ||
              (wb && (rn == rt || rn == rt2 || rn == 15));
    end
  endtask

  task automatic runOp(input bit cmp, input logic [31:0] w, input bit cp, input bit be,
                       input logic [31:0] base, input logic [31:0] a, input logic [31:0] b,
                       input int stall, input bit poke, input string req);
    bit ok, isBad, wb, p, u, go, fin;
    int rn, rt, rt2, imm, nBeats, beat;
    logic [31:0] off, acc;
    logic [63:0] expData;
    model(cmp, w, ok, isBad, wb, p, u, rn, rt, rt2, imm);
    go = cp && ok && !isBad;
    off = u ? base + imm : base - imm;
    acc = p ? off : base;
    nBeats = (acc % 8 == 0) ? 1 : 2;
    @(negedge clk);
    isCompact = cmp; insnWord = w; condPass = cp; bigEndian = be;
    baseVal = base; dataA = a; dataB = b; cmdStart = 1'b1; memReady = 1'b1;
    #1;
    if (ok) begin
      chk(cmp ? "R2" : "R1", "srcIdxA", 64'(srcIdxA), 64'(rt));
      chk(cmp ? "R2" : "R1", "srcIdxB", 64'(srcIdxB), 64'(rt2));
    end
    beat = 0; fin = 0;
    for (int cyc = 0; cyc < 24 && !fin; cyc++) begin
      @(negedge clk);
      cmdStart = 1'b0;
      if (poke && cyc == 0) begin
        cmdStart = 1'b1; baseVal = ~base; dataA = ~a; dataB = ~b; bigEndian = ~be;
      end
      memReady = !stall[cyc % 32];
      #1;
      chk("R12", "busy", 64'(busy), 64'(1));
      if (!go) begin
        chk(req, "done", 64'(done), 64'(1));
        chk(req, "memValid", 64'(memValid), 64'(0));
        chk(req, "undef", 64'(undef), 64'(cp && !(ok && !isBad)));
        chk(req, "wbValid", 64'(wbValid), 64'(0));
        fin = 1;
      end else if (beat < nBeats) begin
        chk("R11", "done", 64'(done), 64'(0));
        chk(req, "memValid", 64'(memValid), 64'(1));
        chk(req, "memWide", 64'(memWide), 64'(nBeats == 1));
        chk(req, "memAddr", 64'(memAddr), 64'(acc + 4 * beat));
        if (nBeats == 1) expData = be ? {a, b} : {b, a};
        else             expData = {32'h0, (beat == 0) ? a : b};
        chk(req, "memData", memData, expData);
        if (memReady) beat++;
      end else begin
        chk("R11", "done", 64'(done), 64'(1));
        chk(req, "memValid", 64'(memValid), 64'(0));
        chk("R6", "undef", 64'(undef), 64'(0));
        chk("R6", "wbValid", 64'(wbValid), 64'(wb));
        if (wb) begin
          chk("R6", "wbValue", 64'(wbValue), 64'(off));
          chk("R6", "wbReg", 64'(wbReg), 64'(rn));
        end
        fin = 1;
      end
    end
    if (!fin) chk(req, "finished", 64'(0), 64'(1));
    cmdStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "reset busy", 64'(busy), 64'(0));
    chk("R11", "reset done", 64'(done), 64'(0));
    chk("R10", "reset memValid", 64'(memValid), 64'(0));
    chk("R6", "reset wbValid", 64'(wbValid), 64'(0));
    rstN = 1'b1;

    // R1 R3 R4: pre-indexed add, aligned, little then big endian with stalls (R10)
    runOp(0, encW(4'hE, 1, 1, 0, 4'd1, 4'd2, 8'h18), 1, 0, 32'h1000, 32'hA1A1A1A1, 32'hB2B2B2B2, 0, 0, "R4");
    runOp(0, encW(4'hE, 1, 1, 0, 4'd1, 4'd2, 8'h18), 1, 1, 32'h1000, 32'h11112222, 32'h33334444, 3, 0, "R10");
    // R3 R5 R6: subtract, pre-indexed with writeback, unaligned, stalled beats
    runOp(0, encW(4'h0, 1, 0, 1, 4'd3, 4'd4, 8'h0C), 1, 0, 32'h2000, 32'hDEADBEEF, 32'hCAFEF00D, 5, 0, "R5");
    // R6: post-indexed 32-bit form writes back
    runOp(0, encW(4'h1, 0, 1, 0, 4'd5, 4'd6, 8'h10), 1, 0, 32'h3004, 32'h01020304, 32'h05060708, 0, 0, "R3");
    // R2: compact form, scaled offset, aligned
    runOp(1, encC(1, 1, 0, 4'd2, 4'd7, 4'd9, 8'h03), 1, 0, 32'h4004, 32'h76543210, 32'hFEDCBA98, 0, 0, "R2");
    // R2 R6 R12: compact post-indexed subtract, start poked while busy
    runOp(1, encC(0, 0, 1, 4'd4, 4'd0, 4'd14, 8'h40), 1, 1, 32'h5000, 32'h0BADCAFE, 32'h12345678, 1, 1, "R12");
    runOp(1, encC(1, 1, 1, 4'd1, 4'd3, 4'd5, 8'h01), 1, 0, 32'h6000, 32'hAAAA5555, 32'h5555AAAA, 2, 1, "R5");
    // R11: same shape, different data: identical cycle timing
    runOp(1, encC(1, 1, 1, 4'd1, 4'd3, 4'd5, 8'h01), 1, 0, 32'h6000, 32'h00000000, 32'hFFFFFFFF, 2, 0, "R11");
    // R7: undefined encodings
    runOp(0, encW(4'hE, 1, 1, 0, 4'd1, 4'd3, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(0, encW(4'hE, 0, 1, 1, 4'd1, 4'd2, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(0, encW(4'hE, 1, 1, 0, 4'd1, 4'd14, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(0, encW(4'hE, 1, 1, 1, 4'd5, 4'd4, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(0, encW(4'hE, 0, 1, 0, 4'd15, 4'd2, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(1, encC(1, 1, 0, 4'd15, 4'd2, 4'd3, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(1, encC(1, 1, 0, 4'd1, 4'd2, 4'd15, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    runOp(1, encC(1, 1, 1, 4'd2, 4'd2, 4'd3, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R7");
    // R8: encodings that do not match
    runOp(0, encW(4'hF, 1, 1, 0, 4'd1, 4'd2, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R8");
    runOp(0, encW(4'hE, 1, 1, 0, 4'd1, 4'd2, 8'h00) & ~32'h20, 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R8");
    runOp(1, encC(0, 1, 0, 4'd1, 4'd2, 4'd3, 8'h00), 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R8");
    runOp(1, encC(1, 1, 0, 4'd1, 4'd2, 4'd3, 8'h00) ^ 32'h2000_0000, 1, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R8");
    // R9: condition failed, valid and undefined encodings alike
    runOp(0, encW(4'hE, 1, 1, 1, 4'd1, 4'd2, 8'h18), 0, 0, 32'h1000, 32'h1, 32'h2, 0, 0, "R9");
    runOp(0, encW(4'hE, 1, 1, 0, 4'd1, 4'd3, 8'h00), 0, 0, 32'h100, 32'h1, 32'h2, 0, 0, "R9");

    repeat (2) @(negedge clk);
    #1;
    chk("R12", "idle busy", 64'(busy), 64'(0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule